// File: doc/BRIEF.md
# Segmented Ring Transfer Arbiter

This block arbitrates and sequences block transfers on an on-chip ring that links twelve units, numbered 0 to 11 around the loop. Any unit may ask to send a 128-byte block to another unit. The arbiter picks a direction by the shorter way around the loop. It then picks one of four unidirectional 16-byte rings, two per direction. It checks that the ring links the block would cross are idle and issues a grant. Each link is numbered after the unit it leaves in the increasing direction.

A granted block moves as eight 16-byte beats from the source's send port to the destination's receive port. Several blocks may share one ring when the links they cross do not overlap. The ring fabric runs at half the core clock, so every arbitration decision, beat and strobe spans one bus cycle of two core clocks. The `bus_tick` output is high in the second core clock of each bus cycle.

A requester holds `req` with a destination ID until it sees its `gnt` pulse, and drops `req` in that bus cycle. A `done` pulse follows once the last beat has reached the destination.

Top module: `ring_xfer_arb`

## Requirements
- R1: Let h = (dst - src) mod 12 be the distance in the increasing direction. When h is at most 5, the block uses an increasing-direction ring (ring ID 0 or 1). When h is at least 7, it uses a decreasing-direction ring (ring ID 2 or 3). When h is 6, both directions are legal: the increasing rings are tried first and the decreasing rings serve as fallback. Within a direction the lower ring ID is tried first.
- R2: A request presented in a bus cycle in which its route is free produces a one-bus-cycle `gnt` pulse to that requester in the next bus cycle, with the chosen ring ID on `gnt_ring`.
- R3: A granted block takes eight beats. `tx_take` of the source is high in eight consecutive bus cycles, starting with the grant cycle, and the source presents beat k on `tx_data` during the k-th of them. Each beat appears on the destination's `rx_data` with `rx_valid` one bus cycle later, in order.
- R4: On any one ring, two starts are at least 3 bus cycles apart. A request that is blocked only by this spacing takes the other ring of the same direction if that ring is open.
- R5: One ring carries at most 3 blocks at a time, and only blocks whose crossed links are disjoint. Link j joins unit j and unit (j+1) mod 12; a block of h hops crosses h links.
- R6: All outputs change only at bus-cycle boundaries. Each strobe lasts exactly two core clocks.
- R7: At most one grant is issued per bus cycle across all rings.
- R8: Eligible requests are served round-robin, starting from the unit after the last granted one. After reset the scan starts at unit 0.
- R9: A destination that is receiving a block cannot be granted a new block until that block has completed.
- R10: `done` of the source pulses in the bus cycle after the last beat's `rx_valid`. In that same bus cycle the ring links, the ring slot and the destination are already free, so a waiting request can be granted in it.
- R11: A request whose destination equals its source, or is 12 or more, is never granted and moves no data.
- R12: Out of reset, `gnt`, `done`, `tx_take` and `rx_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 12 | Per-unit transfer request, held until granted |
| req_dst | input | 48 | Per-unit 4-bit destination ID, unit u in bits [4u+3:4u] |
| gnt | output | 12 | Per-unit grant pulse |
| gnt_ring | output | 2 | Ring ID of the current grant |
| done | output | 12 | Per-unit completion pulse |
| tx_take | output | 12 | Per-unit strobe: the beat on tx_data is taken this bus cycle |
| tx_data | input | 1536 | Per-unit 16-byte send data, unit u in bits [128u+127:128u] |
| rx_valid | output | 12 | Per-unit receive strobe |
| rx_data | output | 1536 | Per-unit 16-byte receive data |
| bus_tick | output | 1 | High in the second core clock of each bus cycle |

## Verification
The release of a finished block and a new grant that reuses its ring links or its destination can fall in the same bus cycle. Two tests provoke this. In the first, five six-hop requests fill all four rings with overlapping link sets, so the fifth request can proceed only once the first block completes. In the second, two sources aim at one destination. In both, the bench expects the first source's `done` pulse and the waiting request's grant decision in the same bus cycle, with the grant visible one bus cycle later. An exhaustive sweep over every source and destination pair checks ring choice, beat order and completion timing against the distance arithmetic.

// File: rtl/ring_arb_pkg.sv
package ring_arb_pkg;

  // Travel direction of a ring; increasing rings hold the lower ring IDs.
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } ring_dir_e;

  // Distance from a to b walking in the increasing direction on an n-unit loop.
  function automatic int fwd_dist(input int a, input int b, input int n);
    return (b - a + n) % n;
  endfunction

endpackage

// File: rtl/ring_seg_route.sv
module ring_seg_route
  import ring_arb_pkg::*;
#(
  parameter int N_UNITS = 12,
  parameter int ID_W    = 4,
  parameter int N_RINGS = 4,
  parameter int SRC     = 0,
  localparam int RING_W  = $clog2(N_RINGS),
  localparam int MAX_HOP = N_UNITS / 2
) (
  input  logic                              req,
  input  logic [ID_W-1:0]                   dst,
  input  logic                              src_busy,
  input  logic                              dst_busy,
  input  logic [N_RINGS-1:0][N_UNITS-1:0]   occ,
  input  logic [N_RINGS-1:0]                ring_open,
  output logic                              ok,
  output logic [RING_W-1:0]                 ring,
  output logic [N_UNITS-1:0]                seg_mask
);

  int                 h_up;
  int                 h_down;
  logic               legal;
  logic               found;
  logic [N_UNITS-1:0] m_up;
  logic [N_UNITS-1:0] m_down;
  logic [N_UNITS-1:0] m_sel;
  logic               dir_ok;
  ring_dir_e          dir;

  always_comb begin
    h_up   = fwd_dist(SRC, int'(dst), N_UNITS);
    h_down = (N_UNITS - h_up) % N_UNITS;
    legal  = (int'(dst) < N_UNITS) && (h_up != 0);
    for (int j = 0; j < N_UNITS; j++) begin
      m_up[j]   = fwd_dist(SRC, j, N_UNITS) < h_up;
      m_down[j] = fwd_dist(j, SRC - 1 + N_UNITS, N_UNITS) < h_down;
    end
    found    = 1'b0;
    ring     = '0;
    seg_mask = '0;
    m_sel    = '0;
    dir_ok   = 1'b0;
    dir      = DIR_UP;
    for (int r = 0; r < N_RINGS; r++) begin
      dir    = (r < N_RINGS / 2) ? DIR_UP : DIR_DOWN;
      dir_ok = (dir == DIR_UP) ? (h_up <= MAX_HOP) : (h_down <= MAX_HOP);
      m_sel  = (dir == DIR_UP) ? m_up : m_down;
      if (!found && dir_ok && ring_open[r] && ((occ[r] & m_sel) == '0)) begin
        found    = 1'b1;
        ring     = RING_W'(r);
        seg_mask = m_sel;
      end
    end
    ok = req && legal && !src_busy && !dst_busy && found;
  end

endmodule

// File: rtl/ring_rr_pick.sv
module ring_rr_pick #(
  parameter int N_UNITS = 12,
  localparam int ID_W = $clog2(N_UNITS)
) (
  input  logic [N_UNITS-1:0] cand,
  input  logic [ID_W-1:0]    ptr,
  output logic               hit,
  output logic [ID_W-1:0]    idx
);

  int c;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    c   = 0;
    for (int k = 0; k < N_UNITS; k++) begin
      c = (int'(ptr) + k) % N_UNITS;
      if (!hit && cand[c]) begin
        hit = 1'b1;
        idx = ID_W'(c);
      end
    end
  end

endmodule

// File: rtl/ring_lane.sv
module ring_lane #(
  parameter int N_UNITS = 12,
  parameter int ID_W    = 4,
  parameter int SLOTS   = 3,
  parameter int BEATS   = 8,
  parameter int GAP     = 3,
  localparam int CNT_W = $clog2(BEATS + 1),
  localparam int SP_W  = $clog2(GAP + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_en,
  input  logic                        start,
  input  logic [ID_W-1:0]             start_src,
  input  logic [ID_W-1:0]             start_dst,
  input  logic [N_UNITS-1:0]          start_mask,
  output logic [N_UNITS-1:0]          occ,
  output logic                        open,
  output logic [SLOTS-1:0]            act,
  output logic [SLOTS-1:0][ID_W-1:0]  src,
  output logic [SLOTS-1:0][ID_W-1:0]  dst,
  output logic [SLOTS-1:0]            take,
  output logic [SLOTS-1:0]            last
);

  logic [SLOTS-1:0]               act_q, act_n;
  logic [SLOTS-1:0][ID_W-1:0]     src_q, src_n, dst_q, dst_n;
  logic [SLOTS-1:0][CNT_W-1:0]    cnt_q, cnt_n;
  logic [SLOTS-1:0][N_UNITS-1:0]  msk_q, msk_n;
  logic [SP_W-1:0]                sp_q, sp_n;
  logic                           placed;

  // next state
  always_comb begin
    act_n  = act_q;
    src_n  = src_q;
    dst_n  = dst_q;
    cnt_n  = cnt_q;
    msk_n  = msk_q;
    placed = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (act_q[i]) begin
        if (cnt_q[i] == CNT_W'(BEATS)) act_n[i] = 1'b0;
        else                           cnt_n[i] = cnt_q[i] + 1'b1;
      end else if (start && !placed) begin
        placed   = 1'b1;
        act_n[i] = 1'b1;
        cnt_n[i] = '0;
        src_n[i] = start_src;
        dst_n[i] = start_dst;
        msk_n[i] = start_mask;
      end
    end
    if (start)                          sp_n = '0;
    else if (sp_q == SP_W'(GAP - 1))    sp_n = sp_q;
    else                                sp_n = sp_q + 1'b1;
  end

  // registers, advanced once per bus cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      msk_q <= '0;
      sp_q  <= SP_W'(GAP - 1);
    end else if (bus_en) begin
      act_q <= act_n;
      src_q <= src_n;
      dst_q <= dst_n;
      cnt_q <= cnt_n;
      msk_q <= msk_n;
      sp_q  <= sp_n;
    end
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (act_q[i]) occ = occ | msk_q[i];
      take[i] = act_q[i] && (cnt_q[i] != CNT_W'(BEATS));
      last[i] = act_q[i] && (cnt_q[i] == CNT_W'(BEATS));
    end
    open = (sp_q == SP_W'(GAP - 1)) && !(&act_q);
    act  = act_q;
    src  = src_q;
    dst  = dst_q;
  end

endmodule

// File: rtl/ring_xfer_arb.sv
module ring_xfer_arb #(
  parameter int N_UNITS = 12,
  parameter int N_RINGS = 4,
  parameter int SLOTS   = 3,
  parameter int BEATS   = 8,
  parameter int GAP     = 3,
  parameter int DATA_W  = 128,
  localparam int ID_W   = $clog2(N_UNITS),
  localparam int RING_W = $clog2(N_RINGS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_UNITS-1:0]            req,
  input  logic [N_UNITS*ID_W-1:0]       req_dst,
  output logic [N_UNITS-1:0]            gnt,
  output logic [RING_W-1:0]             gnt_ring,
  output logic [N_UNITS-1:0]            done,
  output logic [N_UNITS-1:0]            tx_take,
  input  logic [N_UNITS*DATA_W-1:0]     tx_data,
  output logic [N_UNITS-1:0]            rx_valid,
  output logic [N_UNITS*DATA_W-1:0]     rx_data,
  output logic                          bus_tick
);

  logic phase_q;
  logic bus_en;

  logic [N_RINGS-1:0][SLOTS-1:0]             s_act, s_take, s_last;
  logic [N_RINGS-1:0][SLOTS-1:0][ID_W-1:0]   s_src, s_dst;
  logic [N_RINGS-1:0][N_UNITS-1:0]           occ;
  logic [N_RINGS-1:0]                        ring_open, ring_start;

  logic [N_UNITS-1:0]                        src_busy, dst_busy, take_c, fin_c, rx_hit;
  logic [N_UNITS-1:0][ID_W-1:0]              rx_src, dst_arr;
  logic [N_UNITS-1:0]                        cand;
  logic [N_UNITS-1:0][RING_W-1:0]            cand_ring;
  logic [N_UNITS-1:0][N_UNITS-1:0]           cand_mask;
  logic                                      win_hit;
  logic [ID_W-1:0]                           win_idx;

  logic [N_UNITS-1:0]        gnt_q, gnt_n, rxv_q, rxv_n, done_q, done_n;
  logic [RING_W-1:0]         ring_q, ring_n;
  logic [ID_W-1:0]           ptr_q, ptr_n;
  logic [N_UNITS*DATA_W-1:0] rxd_q, rxd_n;

  // half-rate bus phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end
  assign bus_en   = phase_q;
  assign bus_tick = phase_q;

  // occupancy of unit ports by the slots in flight
  always_comb begin
    src_busy = '0;
    dst_busy = '0;
    take_c   = '0;
    fin_c    = '0;
    rx_hit   = '0;
    rx_src   = '0;
    for (int r = 0; r < N_RINGS; r++) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (s_act[r][s]) begin
          src_busy[s_src[r][s]] = 1'b1;
          dst_busy[s_dst[r][s]] = 1'b1;
        end
        if (s_take[r][s]) begin
          take_c[s_src[r][s]] = 1'b1;
          rx_hit[s_dst[r][s]] = 1'b1;
          rx_src[s_dst[r][s]] = s_src[r][s];
        end
        if (s_last[r][s]) fin_c[s_src[r][s]] = 1'b1;
      end
    end
  end

  // per-requester route and legality
  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    assign dst_arr[u] = req_dst[u*ID_W +: ID_W];
    ring_seg_route #(
      .N_UNITS (N_UNITS),
      .ID_W    (ID_W),
      .N_RINGS (N_RINGS),
      .SRC     (u)
    ) u_route (
      .req       (req[u]),
      .dst       (dst_arr[u]),
      .src_busy  (src_busy[u]),
      .dst_busy  (dst_busy[dst_arr[u]]),
      .occ       (occ),
      .ring_open (ring_open),
      .ok        (cand[u]),
      .ring      (cand_ring[u]),
      .seg_mask  (cand_mask[u])
    );
  end

  ring_rr_pick #(.N_UNITS(N_UNITS)) u_pick (
    .cand (cand),
    .ptr  (ptr_q),
    .hit  (win_hit),
    .idx  (win_idx)
  );

  // one lane per ring
  for (genvar r = 0; r < N_RINGS; r++) begin : g_ring
    assign ring_start[r] = win_hit && (cand_ring[win_idx] == RING_W'(r));
    ring_lane #(
      .N_UNITS (N_UNITS),
      .ID_W    (ID_W),
      .SLOTS   (SLOTS),
      .BEATS   (BEATS),
      .GAP     (GAP)
    ) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_en     (bus_en),
      .start      (ring_start[r]),
      .start_src  (win_idx),
      .start_dst  (dst_arr[win_idx]),
      .start_mask (cand_mask[win_idx]),
      .occ        (occ[r]),
      .open       (ring_open[r]),
      .act        (s_act[r]),
      .src        (s_src[r]),
      .dst        (s_dst[r]),
      .take       (s_take[r]),
      .last       (s_last[r])
    );
  end

  // next state of the edge registers
  always_comb begin
    gnt_n  = '0;
    ring_n = '0;
    ptr_n  = ptr_q;
    if (win_hit) begin
      gnt_n[win_idx] = 1'b1;
      ring_n         = cand_ring[win_idx];
      ptr_n          = (win_idx == ID_W'(N_UNITS - 1)) ? '0 : win_idx + 1'b1;
    end
    rxv_n  = rx_hit;
    done_n = fin_c;
    rxd_n  = rxd_q;
    for (int u = 0; u < N_UNITS; u++) begin
      if (rx_hit[u]) rxd_n[u*DATA_W +: DATA_W] = tx_data[int'(rx_src[u])*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      ring_q <= '0;
      ptr_q  <= '0;
      rxv_q  <= '0;
      done_q <= '0;
      rxd_q  <= '0;
    end else if (bus_en) begin
      gnt_q  <= gnt_n;
      ring_q <= ring_n;
      ptr_q  <= ptr_n;
      rxv_q  <= rxv_n;
      done_q <= done_n;
      rxd_q  <= rxd_n;
    end
  end

  assign gnt      = gnt_q;
  assign gnt_ring = ring_q;
  assign done     = done_q;
  assign tx_take  = take_c;
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;

endmodule

// File: rtl/ring_xfer_arb_chk.sv
module ring_xfer_arb_chk #(
  parameter int N_UNITS = 12,
  parameter int N_RINGS = 4,
  parameter int GAP     = 3,
  localparam int RING_W = $clog2(N_RINGS),
  localparam int SP_W   = $clog2(GAP + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_tick,
  input logic [N_UNITS-1:0]  gnt,
  input logic [RING_W-1:0]   gnt_ring,
  input logic [N_UNITS-1:0]  done,
  input logic [N_UNITS-1:0]  tx_take,
  input logic [N_UNITS-1:0]  rx_valid
);

  // bus cycles since the last visible start on each ring, saturating
  logic [N_RINGS-1:0][SP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N_RINGS; r++) gap_q[r] <= SP_W'(GAP - 1);
    end else if (bus_tick) begin
      for (int r = 0; r < N_RINGS; r++) begin
        if ((gnt != '0) && (gnt_ring == RING_W'(r))) gap_q[r] <= '0;
        else if (gap_q[r] != SP_W'(GAP - 1))         gap_q[r] <= gap_q[r] + 1'b1;
      end
    end
  end

  assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_half_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_tick |=> ($stable(gnt) && $stable(done) && $stable(tx_take) && $stable(rx_valid)));

  assert_start_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_tick && (gnt != '0)) |-> (gap_q[gnt_ring] == SP_W'(GAP - 1)));

  assert_grant_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> ((tx_take & gnt) == gnt));

  assert_done_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done & tx_take) == '0);

endmodule

bind ring_xfer_arb ring_xfer_arb_chk #(
  .N_UNITS (N_UNITS),
  .N_RINGS (N_RINGS),
  .GAP     (GAP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_tick (bus_tick),
  .gnt      (gnt),
  .gnt_ring (gnt_ring),
  .done     (done),
  .tx_take  (tx_take),
  .rx_valid (rx_valid)
);

// File: tb/ring_xfer_arb_test.sv
module ring_xfer_arb_test;

  localparam int N  = 12;
  localparam int DW = 128;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    req;
  logic [N*4-1:0]  req_dst;
  logic [N-1:0]    gnt;
  logic [1:0]      gnt_ring;
  logic [N-1:0]    done;
  logic [N-1:0]    tx_take;
  logic [N*DW-1:0] tx_data;
  logic [N-1:0]    rx_valid;
  logic [N*DW-1:0] rx_data;
  logic            bus_tick;

  ring_xfer_arb uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_dst  (req_dst),
    .gnt      (gnt),
    .gnt_ring (gnt_ring),
    .done     (done),
    .tx_take  (tx_take),
    .tx_data  (tx_data),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .bus_tick (bus_tick)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int errors = 0;
  int checks = 0;
  int cyc;
  int gnt_at [N];
  int gnt_rg [N];
  int done_at[N];
  int sent   [N];
  int rx_n   [N];
  int rx_last[N];
  int exp_src[N];
  int cur_dst[N];
  int rx_bad;
  int gnt_total;
  int take_total;
  int rx_total;
  int rx_clk_hi;
  int core_cnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    core_cnt++;
    if (core_cnt > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", core_cnt, 150000);
      finish_run();
    end
  end

  always @(negedge clk) rx_clk_hi += $countones(rx_valid);

  task automatic clear_log();
    for (int u = 0; u < N; u++) begin
      gnt_at[u] = -1; gnt_rg[u] = -1; done_at[u] = -1;
      sent[u] = 0; rx_n[u] = 0; rx_last[u] = -1; exp_src[u] = 0;
    end
    rx_bad = 0; gnt_total = 0; take_total = 0; rx_total = 0; rx_clk_hi = 0;
  endtask

  // advance to the sampling point of the next bus cycle, then observe and serve
  task automatic step();
    logic [7:0] b;
    do @(negedge clk); while (!bus_tick);
    cyc++;
    for (int u = 0; u < N; u++) begin
      if (gnt[u]) begin
        gnt_at[u] = cyc; gnt_rg[u] = int'(gnt_ring); req[u] = 1'b0; gnt_total++;
        if (cur_dst[u] < N) exp_src[cur_dst[u]] = u;
      end
      if (tx_take[u]) begin
        b = {4'(u), 4'(sent[u])};
        tx_data[u*DW +: DW] = {16{b}};
        sent[u]++; take_total++;
      end
      if (rx_valid[u]) begin
        b = {4'(exp_src[u]), 4'(rx_n[u] % 8)};
        if (rx_data[u*DW +: DW] != {16{b}}) rx_bad++;
        rx_n[u]++; rx_last[u] = cyc; rx_total++;
      end
      if (done[u]) done_at[u] = cyc;
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic ask(input int s, input int d);
    cur_dst[s] = d;
    req_dst[s*4 +: 4] = 4'(d);
    req[s] = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; req_dst = '0; tx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_log();
    for (int u = 0; u < N; u++) cur_dst[u] = 0;
    do @(negedge clk); while (!bus_tick);
    cyc = 0;
  endtask

  initial begin
    int base;
    int h;
    int er;
    do_reset();

    // R12: outputs quiet after reset
    check(gnt == '0 && done == '0, "R12 gnt/done at reset", int'(gnt | done), 0);
    check(tx_take == '0 && rx_valid == '0, "R12 take/valid at reset", int'(tx_take | rx_valid), 0);

    // exhaustive sweep over all source/destination pairs, one at a time
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < N; d++) begin
        if (d != s) begin
          clear_log();
          base = cyc;
          h  = (d - s + N) % N;
          er = (h <= 6) ? 0 : 2;
          ask(s, d);
          steps(12);
          check(gnt_at[s] == base + 1 && gnt_rg[s] == er,
                $sformatf("R1 R2 route %0d->%0d ring", s, d), gnt_rg[s], er);
          check(sent[s] == 8 && rx_n[d] == 8 && rx_bad == 0 && rx_last[d] == base + 9,
                $sformatf("R3 beats %0d->%0d", s, d), rx_n[d] * 100 + rx_bad, 800);
          check(rx_clk_hi == 16, $sformatf("R6 strobe clocks %0d->%0d", s, d), rx_clk_hi, 16);
          check(done_at[s] == base + 10, $sformatf("R10 done %0d->%0d", s, d), done_at[s] - base, 10);
        end
      end
    end

    // spacing and sharing on the increasing rings
    do_reset();
    ask(0, 2); ask(4, 6); ask(8, 10);
    steps(16);
    check(gnt_at[0] == 1 && gnt_rg[0] == 0, "R8 first start ring0", gnt_rg[0], 0);
    check(gnt_at[4] == 2 && gnt_rg[4] == 1, "R4 spacing picks ring1", gnt_rg[4] * 10 + gnt_at[4], 12);
    check(gnt_at[8] == 4 && gnt_rg[8] == 0, "R4 R5 third start shares ring0", gnt_rg[8] * 10 + gnt_at[8], 4);
    check(rx_n[2] == 8 && rx_n[6] == 8 && rx_n[10] == 8 && rx_bad == 0,
          "R3 concurrent beats", rx_total, 24);
    check(done_at[8] == 13, "R10 done of shared transfer", done_at[8], 13);

    // six-hop fallback, overlap blocking, release and regrant in one cycle
    do_reset();
    ask(0, 6); ask(1, 7); ask(2, 8); ask(3, 9); ask(4, 10);
    steps(24);
    check(gnt_rg[1] == 1 && gnt_at[1] == 2, "R1 six hops second inc ring", gnt_rg[1], 1);
    check(gnt_rg[2] == 2 && gnt_at[2] == 3, "R1 six hops falls back to ring2", gnt_rg[2], 2);
    check(gnt_rg[3] == 3 && gnt_at[3] == 4, "R5 overlap on ring0 forces ring3", gnt_rg[3], 3);
    check(done_at[0] == 10, "R10 first done", done_at[0], 10);
    check(gnt_at[4] == 11 && gnt_rg[4] == 0, "R5 R10 blocked until release", gnt_at[4], 11);
    check(rx_n[10] == 8 && rx_bad == 0, "R3 late transfer beats", rx_n[10], 8);

    // busy destination
    do_reset();
    ask(0, 5); ask(3, 5);
    steps(24);
    check(gnt_at[0] == 1 && gnt_at[3] == 11, "R9 second sender waits", gnt_at[3], 11);
    check(gnt_rg[3] == 0, "R9 regrant ring", gnt_rg[3], 0);
    check(rx_n[5] == 16 && rx_bad == 0, "R9 both blocks received in order", rx_n[5], 16);

    // round-robin order
    do_reset();
    ask(5, 6); ask(2, 3);
    steps(14);
    check(gnt_at[2] == 1 && gnt_at[5] == 2, "R8 scan from unit 0", gnt_at[2], 1);
    check(gnt_total == 2, "R7 one grant per cycle", gnt_total, 2);
    clear_log();
    base = cyc;
    ask(3, 4); ask(8, 9);
    steps(14);
    check(gnt_at[8] == base + 1, "R8 scan resumes after last grant", gnt_at[8] - base, 1);
    check(gnt_at[3] == base + 2 && gnt_rg[3] == 1, "R8 second in order", gnt_at[3] - base, 2);

    // ignored destinations
    do_reset();
    ask(7, 7); ask(9, 13);
    steps(20);
    check(gnt_total == 0, "R11 no grant for self or bad id", gnt_total, 0);
    check(take_total == 0 && rx_total == 0, "R11 no data moved", take_total + rx_total, 0);
    req = '0;

    finish_run();
  end

endmodule